// File: doc/BRIEF.md
# Slow Crystal Frequency Monitor

This block watches a slow crystal oscillator clock from a faster reference clock and grades its health. Two flip-flops bring the slow clock into the reference domain. After that, the block counts rising edges over fixed windows of reference cycles. At the end of each window it places the count in one of three classes: in range, out of range with edges still present, or no edges at all. Saturating counters track how many windows in a row fall into each bad class.

The block reports a two-bit status code and a sticky error flag. A wrong frequency is reported only after it has lasted for a number of consecutive windows. A complete loss of edges is reported sooner. A single-cycle read strobe clears both outputs. If a new error event is detected in the same cycle as a read, the event is kept.

All sizes are parameters: the window length in reference cycles, the inclusive bounds on the edge count, and the two persistence thresholds.

Top module: `slow_xtal_freq_mon`

## Requirements
- R1: After a synchronous reset, `status` is 0 and `err_flag` is 0.
- R2: `status` encodes 0 = good, 1 = frequency error and 2 = clock lost. The value 3 never appears.
- R3: Every WINDOW_CYCLES reference cycles, the block counts the rising edges of the synchronized slow clock in that window. A non-zero count is in range when MIN_EDGES <= count <= MAX_EDGES, with both bounds included.
- R4: `status` becomes 1 at the end of the ERR_WINDOWS-th consecutive window whose count is non-zero and out of range. Any other kind of window, including one with no edges, restarts this run.
- R5: `status` becomes 2 at the end of the LOSS_WINDOWS-th consecutive window with no edges. Any window with at least one edge restarts this run.
- R6: An in-range window sets `status` back to 0. A bad window that has not yet reached its threshold leaves `status` unchanged.
- R7: `err_flag` is set whenever a frequency-error or lost event occurs. It then stays set through good windows until it is read. `status` is never non-zero while `err_flag` is 0.
- R8: A one-cycle `rd_stb` clears both `status` and `err_flag` on the next clock edge.
- R9: If an event occurs in the same cycle as `rd_stb`, the event wins: `status` takes the event's code and `err_flag` stays 1.
- R10: While a bad condition persists after its threshold, every further window reports it again. A cleared status therefore returns at the next window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Monitored slow clock, asynchronous to clk |
| rd_stb | input | 1 | One-cycle status read strobe; clears status and error flag |
| status | output | 2 | Health code: 0 good, 1 frequency error, 2 lost |
| err_flag | output | 1 | Sticky error, set by any event, cleared by read |

## Verification
The bench places an exact number of edges in each window, from zero up to well above the upper bound, and steps through every count. This exposes an off-by-one on either bound or on either persistence threshold, because such a design would flag errors one window early or late, or flag the boundary counts 3 and 5. Mixed window sequences check that a good window or a no-edge window breaks a run of frequency errors, and that edge windows break a loss run. A design that kept counting across these breaks would raise false errors. Reads are placed both away from and exactly on the cycle when a window is judged. A design that gave the read priority would lose a live failure. A design that tied the error flag to the status would drop the flag after a recovery window.

// File: rtl/sxm_pkg.sv
package sxm_pkg;

  typedef enum logic [1:0] {
    SXM_GOOD = 2'd0,
    SXM_FREQ = 2'd1,
    SXM_LOST = 2'd2
  } sxm_code_e;

endpackage

// File: rtl/sxm_edge_sync.sv
module sxm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  // chain[LAST-1] is the settled sample, chain[LAST] the one before it
  assign rise = chain[LAST-1] & ~chain[LAST];

endmodule

// File: rtl/sxm_window.sv
module sxm_window #(
  parameter int WINDOW_CYCLES = 1024,
  parameter int EDGE_W        = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  output logic              win_done,
  output logic [EDGE_W-1:0] win_edges
);

  localparam int CYC_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CYC_W-1:0]  CYC_LAST = CYC_W'(WINDOW_CYCLES - 1);
  localparam logic [EDGE_W-1:0] EDGE_TOP = '1;

  logic [CYC_W-1:0]  cyc;
  logic [EDGE_W-1:0] edge_cnt;
  logic [EDGE_W-1:0] edge_now;
  logic              at_end;

  always_comb begin
    at_end = (cyc == CYC_LAST);
    if (rise && edge_cnt != EDGE_TOP) edge_now = edge_cnt + EDGE_W'(1);
    else                               edge_now = edge_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc       <= '0;
      edge_cnt  <= '0;
      win_done  <= 1'b0;
      win_edges <= '0;
    end else begin
      win_done <= at_end;
      if (at_end) begin
        cyc       <= '0;
        edge_cnt  <= '0;
        win_edges <= edge_now;
      end else begin
        cyc      <= cyc + CYC_W'(1);
        edge_cnt <= edge_now;
      end
    end
  end

endmodule

// File: rtl/sxm_judge.sv
module sxm_judge
  import sxm_pkg::*;
#(
  parameter int EDGE_W       = 11,
  parameter int MIN_EDGES    = 30,
  parameter int MAX_EDGES    = 34,
  parameter int ERR_WINDOWS  = 4,
  parameter int LOSS_WINDOWS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_done,
  input  logic [EDGE_W-1:0] win_edges,
  input  logic              rd_stb,
  output logic [1:0]        status,
  output logic              err_flag
);

  localparam int BAD_W  = $clog2(ERR_WINDOWS + 1);
  localparam int LOSS_W = $clog2(LOSS_WINDOWS + 1);
  localparam logic [BAD_W-1:0]  BAD_SAT  = BAD_W'(ERR_WINDOWS);
  localparam logic [LOSS_W-1:0] LOSS_SAT = LOSS_W'(LOSS_WINDOWS);
  localparam logic [EDGE_W-1:0] LO       = EDGE_W'(MIN_EDGES);
  localparam logic [EDGE_W-1:0] HI       = EDGE_W'(MAX_EDGES);

  sxm_code_e         code_q;
  logic [BAD_W-1:0]  bad_run, bad_nx;
  logic [LOSS_W-1:0] loss_run, loss_nx;
  logic              no_edge, in_rng, off_rng;
  logic              freq_evt, lost_evt, good_win;

  always_comb begin
    no_edge = (win_edges == '0);
    in_rng  = !no_edge && (win_edges >= LO) && (win_edges <= HI);
    off_rng = !no_edge && !in_rng;

    if (!off_rng)               bad_nx = '0;
    else if (bad_run == BAD_SAT) bad_nx = bad_run;
    else                        bad_nx = bad_run + BAD_W'(1);

    if (!no_edge)                 loss_nx = '0;
    else if (loss_run == LOSS_SAT) loss_nx = loss_run;
    else                          loss_nx = loss_run + LOSS_W'(1);

    freq_evt = win_done && off_rng && (bad_nx >= BAD_SAT);
    lost_evt = win_done && no_edge && (loss_nx >= LOSS_SAT);
    good_win = win_done && in_rng;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_run  <= '0;
      loss_run <= '0;
      code_q   <= SXM_GOOD;
      err_flag <= 1'b0;
    end else begin
      if (win_done) begin
        bad_run  <= bad_nx;
        loss_run <= loss_nx;
      end
      // events outrank a read in the same cycle
      if (lost_evt)                 code_q <= SXM_LOST;
      else if (freq_evt)            code_q <= SXM_FREQ;
      else if (rd_stb || good_win)  code_q <= SXM_GOOD;

      if (lost_evt || freq_evt)     err_flag <= 1'b1;
      else if (rd_stb)              err_flag <= 1'b0;
    end
  end

  assign status = code_q;

endmodule

// File: rtl/slow_xtal_freq_mon.sv
module slow_xtal_freq_mon #(
  parameter int WINDOW_CYCLES = 1024,
  parameter int MIN_EDGES     = 30,
  parameter int MAX_EDGES     = 34,
  parameter int ERR_WINDOWS   = 4,
  parameter int LOSS_WINDOWS  = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_clk,
  input  logic       rd_stb,
  output logic [1:0] status,
  output logic       err_flag
);

  localparam int EDGE_W = $clog2(WINDOW_CYCLES + 1);

  logic              rise;
  logic              win_done;
  logic [EDGE_W-1:0] win_edges;

  sxm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (slow_clk),
    .rise     (rise)
  );

  sxm_window #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .EDGE_W        (EDGE_W)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .win_done  (win_done),
    .win_edges (win_edges)
  );

  sxm_judge #(
    .EDGE_W       (EDGE_W),
    .MIN_EDGES    (MIN_EDGES),
    .MAX_EDGES    (MAX_EDGES),
    .ERR_WINDOWS  (ERR_WINDOWS),
    .LOSS_WINDOWS (LOSS_WINDOWS)
  ) u_judge (
    .clk       (clk),
    .rst       (rst),
    .win_done  (win_done),
    .win_edges (win_edges),
    .rd_stb    (rd_stb),
    .status    (status),
    .err_flag  (err_flag)
  );

endmodule

// File: rtl/sxm_checker.sv
module sxm_checker #(
  parameter int EDGE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic              win_done,
  input logic [EDGE_W-1:0] win_edges,
  input logic [1:0]        status,
  input logic              err_flag
);

  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    status != 2'd3);

  p_window_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done);

  p_freq_needs_edges_r4: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd1 && $past(status) != 2'd1) |->
      ($past(win_done) && $past(win_edges) != '0));

  p_lost_needs_silence_r5: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd2 && $past(status) != 2'd2) |->
      ($past(win_done) && $past(win_edges) == '0));

  p_err_covers_status_r7: assert property (@(posedge clk) disable iff (rst)
    (status != 2'd0) |-> err_flag);

  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && !win_done) |=> ($stable(status) && $stable(err_flag)));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !win_done) |=> (status == 2'd0 && !err_flag));

endmodule

bind slow_xtal_freq_mon sxm_checker #(.EDGE_W(EDGE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_stb    (rd_stb),
  .win_done  (win_done),
  .win_edges (win_edges),
  .status    (status),
  .err_flag  (err_flag)
);

// File: tb/slow_xtal_freq_mon_test.sv
module slow_xtal_freq_mon_test;

  localparam int WIN  = 32;
  localparam int LO   = 3;
  localparam int HI   = 5;
  localparam int NERR = 4;
  localparam int NLOS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_clk = 1'b0;
  logic       rd_stb = 1'b0;
  logic [1:0] status;
  logic       err_flag;

  int bc = 0;
  int cur_e = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_bad, m_loss, m_st, m_err;
  bit pend_valid;
  int pend_e;

  slow_xtal_freq_mon #(
    .WINDOW_CYCLES (WIN),
    .MIN_EDGES     (LO),
    .MAX_EDGES     (HI),
    .ERR_WINDOWS   (NERR),
    .LOSS_WINDOWS  (NLOS)
  ) uut (
    .clk      (clk),
    .rst      (rst),
    .slow_clk (slow_clk),
    .rd_stb   (rd_stb),
    .status   (status),
    .err_flag (err_flag)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) bc <= 0;
    else     bc <= bc + 1;
  end

  // exactly cur_e one-cycle pulses per window, at phases 2, 5, 8, ...
  always @(negedge clk) begin : gen_pulses
    int ph;
    ph = bc % WIN;
    slow_clk = (cur_e > 0) && (ph >= 2) && (((ph - 2) % 3) == 0) &&
               (((ph - 2) / 3) < cur_e);
  end

  task automatic at_phase(input int p);
    while ((bc % WIN) != p) @(negedge clk);
  endtask

  task automatic chk(input string tag);
    checks++;
    if (status !== 2'(m_st) || err_flag !== 1'(m_err)) begin
      fails++;
      $display("FAIL %s: status=%0d err=%0d expected status=%0d err=%0d",
               tag, status, err_flag, m_st, m_err);
    end
  endtask

  task automatic model_apply(input int e, input bit rd);
    bit ev;
    ev = 1'b0;
    if (!pend_valid) begin
      if (rd) begin m_st = 0; m_err = 0; end
      return;
    end
    if (e == 0) begin
      m_loss = (m_loss + 1 > NLOS) ? NLOS : m_loss + 1;
      m_bad  = 0;
      if (m_loss >= NLOS) begin ev = 1'b1; m_st = 2; end
    end else if (e < LO || e > HI) begin
      m_bad  = (m_bad + 1 > NERR) ? NERR : m_bad + 1;
      m_loss = 0;
      if (m_bad >= NERR) begin ev = 1'b1; m_st = 1; end
    end else begin
      m_bad = 0; m_loss = 0; m_st = 0;
    end
    if (ev) m_err = 1;
    else if (rd) begin m_st = 0; m_err = 0; end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rd_stb = 1'b0;
    cur_e = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_bad = 0; m_loss = 0; m_st = 0; m_err = 0;
    pend_valid = 1'b0;
    pend_e = 0;
  endtask

  // mode 0: no read, 1: read on the judging cycle, 2: read mid-window
  task automatic step(input int e, input int mode, input string tag);
    cur_e = e;
    at_phase(0);
    if (mode == 1) begin
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
    end
    model_apply(pend_e, mode == 1);
    at_phase(10);
    chk(tag);
    if (mode == 2) begin
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      m_st = 0; m_err = 0;
      chk("R8 read clears");
    end
    at_phase(WIN - 1);
    pend_e = e;
    pend_valid = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // sweep every per-window edge count, boundaries included
    for (int e = 0; e <= 8; e++) begin
      do_reset();
      step(e, 0, "R1 reset state");
      for (int w = 0; w < 5; w++) begin
        if (e == 0)               step(e, 0, "R5 loss run");
        else if (e < LO || e > HI) step(e, 0, "R4 freq run");
        else                      step(e, 0, "R3 in range");
      end
      step(4, 0, "R6 recovery R2");
    end

    // sticky flag survives recovery, read clears it
    do_reset();
    for (int w = 0; w < 5; w++) step(7, 0, "R4 freq error");
    step(4, 0, "R10 persists");
    step(4, 0, "R7 sticky after good");
    step(4, 2, "R7 before read");
    step(4, 0, "R8 after read");

    // runs broken by other window kinds
    do_reset();
    step(7, 0, "R4"); step(7, 0, "R4"); step(7, 0, "R4");
    step(4, 0, "R4 good breaks run");
    step(7, 0, "R4"); step(7, 0, "R4"); step(7, 0, "R4");
    step(0, 0, "R4 silent breaks run");
    step(7, 0, "R4"); step(7, 0, "R4"); step(7, 0, "R4"); step(7, 0, "R4");
    step(0, 0, "R4 four after break");
    step(2, 0, "R5 edge breaks loss");
    step(0, 0, "R5");
    step(4, 0, "R5 single silent window");
    step(4, 0, "R6");

    // read collisions and re-reporting
    do_reset();
    step(0, 0, "R5"); step(0, 0, "R5"); step(0, 0, "R5");
    step(0, 1, "R9 event beats read");
    step(0, 2, "R9 before read");
    step(7, 0, "R10 re-reported");
    step(7, 0, "R6 hold below threshold");
    step(4, 1, "R6 hold then read");
    step(4, 1, "R9 read on quiet judge");
    step(4, 0, "R8 cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule